// File: doc/BRIEF.md
# Memory Region Fill Engine

The block writes a repeating pattern over a contiguous range of memory through a 64-bit word write port. Software programs four 32-bit registers: a range base, a range limit, a pattern value and a control word. Setting the go bit in the control word starts the fill. The engine then issues one write per 64-bit word, working from the base up to the limit. It packs 16-bit, 24-bit or 32-bit pattern units into each word, and it carries the 24-bit pattern phase across word boundaries so that the byte stream has no seams.

The base and limit registers count in 8-byte units, so each count is one bus word. A write aimed at count `n` goes out on the port as byte address `n*8`. The go bit reads back as a busy flag while the fill runs and clears itself when the fill ends. At that moment a finished flag sets and a one-cycle done pulse appears. The write port uses a valid/ready handshake. The engine stalls while ready is low and never drops or skips a word.

Top module: `fill_engine`

## Requirements
- R1: The registers decode on `cfg_addr` / `cfg_raddr`: 0 is the base, 1 is the limit, 2 is the pattern value and 3 is control. When idle, the base, limit and value read back exactly as written. After reset all four read as zero.
- R2: The k-th accepted write of a fill (k counted from 0) carries byte address `(base + k) * 8` on `wr_addr`.
- R3: The range is half-open. A fill makes exactly `limit - base` accepted writes when limit is greater than base. Otherwise it makes none and still completes.
- R4: Control bit 0 is go/busy. Writing 1 while idle starts a fill. The bit reads 1 from the cycle after that write until the fill completes, and 0 afterwards.
- R5: Control bit 1 is finished. It reads 1 after a fill completes and 0 from the start of the next fill. Control bits 8 and 9 read back as last written.
- R6: With control bits 9 and 8 both 0 (16-bit units), data byte lane j of a word (bits `[8j+7:8j]`) at fill byte offset o = 8k + j holds value byte (o mod 2).
- R7: With bit 9 = 0 and bit 8 = 1 (24-bit units), the byte at fill offset o holds value byte (o mod 3). Value bits [7:0] come first, then [15:8], then [23:16], and the phase continues across words.
- R8: With bit 9 = 1 (32-bit units), the byte at fill offset o holds value byte (o mod 4), whether bit 8 is 0 or 1.
- R9: While busy, every register write is ignored, including a new go, a new unit selection, a new base, limit or value.
- R10: When `wr_valid` is high and `wr_ready` is low, the next cycle keeps `wr_valid` high with the same `wr_addr` and `wr_data`.
- R11: `fill_done` goes high for exactly one cycle per fill. In that cycle control reads busy 0 and finished 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register write index |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 2 | Register read index |
| cfg_rdata | output | 32 | Register read data (combinational) |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted by memory |
| wr_addr | output | 35 | Byte address of the 64-bit word |
| wr_data | output | 64 | Packed pattern word |
| fill_done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every unit selection, including the case with both mode bits set, over several bases and lengths from zero to nine words. Each sweep runs with ready held high, with ready toggling and with a pseudo-random ready. Every accepted word is compared against an expected pattern computed from the fill byte offset. A design that reset the 24-bit phase at each word would corrupt the second word, and one that gave 24-bit mode priority over 32-bit would fail the both-bits case. An off-by-one in the limit compare would show up as one extra or one missing write, and the zero-length and inverted ranges would expose a design that wrote before testing the range. A go written mid-fill with a different mode and address checks that the running fill is left untouched. A stalled request is checked for a changed address or a dropped word.

// File: rtl/fill_pkg.sv
package fill_pkg;

    typedef enum logic [1:0] {
        UNIT16 = 2'd0,
        UNIT24 = 2'd1,
        UNIT32 = 2'd2
    } unit_e;

    localparam logic [1:0] REG_BASE  = 2'd0;
    localparam logic [1:0] REG_LIMIT = 2'd1;
    localparam logic [1:0] REG_VALUE = 2'd2;
    localparam logic [1:0] REG_CTRL  = 2'd3;

    localparam int CTRL_GO  = 0;
    localparam int CTRL_FIN = 1;
    localparam int CTRL_U24 = 8;
    localparam int CTRL_U32 = 9;

endpackage

// File: rtl/fill_regs.sv
module fill_regs
    import fill_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        waddr_i,
    input  logic [31:0]       wdata_i,
    input  logic [1:0]        raddr_i,
    output logic [31:0]       rdata_o,
    input  logic              busy_i,
    input  logic              finished_i,
    output logic              go_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] limit_o,
    output logic [31:0]       pattern_o,
    output unit_e             unit_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic [31:0]       pattern;
        logic              u24;
        logic              u32;
    } regs_t;

    regs_t r_d, r_q;
    logic  accept;

    always_comb begin
        r_d    = r_q;
        go_o   = 1'b0;
        accept = we_i && !busy_i;
        if (accept) begin
            case (waddr_i)
                REG_BASE:  r_d.base    = wdata_i[ADDR_W-1:0];
                REG_LIMIT: r_d.limit   = wdata_i[ADDR_W-1:0];
                REG_VALUE: r_d.pattern = wdata_i;
                default: begin
                    r_d.u24 = wdata_i[CTRL_U24];
                    r_d.u32 = wdata_i[CTRL_U32];
                    go_o    = wdata_i[CTRL_GO];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (raddr_i)
            REG_BASE:  rdata_o = 32'(r_q.base);
            REG_LIMIT: rdata_o = 32'(r_q.limit);
            REG_VALUE: rdata_o = r_q.pattern;
            default: begin
                rdata_o[CTRL_GO]  = busy_i;
                rdata_o[CTRL_FIN] = finished_i;
                rdata_o[CTRL_U24] = r_q.u24;
                rdata_o[CTRL_U32] = r_q.u32;
            end
        endcase
    end

    always_comb begin
        if (r_q.u32) begin
            unit_o = UNIT32;
        end else if (r_q.u24) begin
            unit_o = UNIT24;
        end else begin
            unit_o = UNIT16;
        end
    end

    assign base_o    = r_q.base;
    assign limit_o   = r_q.limit;
    assign pattern_o = r_q.pattern;

    // R9: configuration is frozen for the whole run
    a_r9_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(r_q.base) && $stable(r_q.limit) &&
                    $stable(r_q.pattern) && $stable(r_q.u24) && $stable(r_q.u32)));

endmodule

// File: rtl/fill_packer.sv
module fill_packer
    import fill_pkg::*;
#(
    parameter int BUS_W = 64
) (
    input  logic [31:0]      pattern_i,
    input  unit_e            unit_i,
    input  logic [1:0]       phase_i,
    output logic [BUS_W-1:0] word_o
);

    localparam int LANES = BUS_W / 8;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [3:0] sum24;
        logic [1:0] sel;

        always_comb begin
            sum24 = {2'b00, phase_i} + 4'(k % 3);
            case (unit_i)
                UNIT32:  sel = 2'(k % 4);
                UNIT24:  sel = 2'(sum24 % 4'd3);
                default: sel = 2'(k % 2);
            endcase
        end

        assign word_o[8*k +: 8] = pattern_i[8*sel +: 8];
    end

endmodule

// File: rtl/fill_seq.sv
module fill_seq #(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] limit_i,
    input  logic              wr_ready_i,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] cur_o,
    output logic [1:0]        phase_o,
    output logic              busy_o,
    output logic              finished_o,
    output logic              done_o
);

    localparam int LANES = BUS_W / 8;
    localparam int PSTEP = LANES % 3;

    typedef struct packed {
        logic              busy;
        logic              finished;
        logic              done;
        logic [ADDR_W-1:0] cur;
        logic [1:0]        phase;
    } seq_t;

    seq_t       s_d, s_q;
    logic       in_range;
    logic [2:0] psum;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        in_range = s_q.cur < limit_i;
        psum     = {1'b0, s_q.phase} + 3'(PSTEP);
        if (!s_q.busy) begin
            if (go_i) begin
                s_d.busy     = 1'b1;
                s_d.finished = 1'b0;
                s_d.cur      = base_i;
                s_d.phase    = 2'd0;
            end
        end else if (!in_range) begin
            s_d.busy     = 1'b0;
            s_d.finished = 1'b1;
            s_d.done     = 1'b1;
        end else if (wr_ready_i) begin
            s_d.cur   = s_q.cur + 1'b1;
            s_d.phase = (psum >= 3'd3) ? 2'(psum - 3'd3) : psum[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_valid_o = s_q.busy && in_range;
    assign cur_o      = s_q.cur;
    assign phase_o    = s_q.phase;
    assign busy_o     = s_q.busy;
    assign finished_o = s_q.finished;
    assign done_o     = s_q.done;

    // R7: the 24-bit phase stays inside its three legal values
    a_r7_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase != 2'd3);

    // R11: completion state accompanies the pulse
    a_r11_done_state: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (!s_q.busy && s_q.finished));

    // R4: a started fill is busy on the next cycle
    a_r4_go_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !s_q.busy) |=> s_q.busy);

endmodule

// File: rtl/fill_engine.sv
module fill_engine
    import fill_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [1:0]                    cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    input  logic [1:0]                    cfg_raddr,
    output logic [31:0]                   cfg_rdata,
    output logic                          wr_valid,
    input  logic                          wr_ready,
    output logic [ADDR_W+$clog2(BUS_W/8)-1:0] wr_addr,
    output logic [BUS_W-1:0]              wr_data,
    output logic                          fill_done
);

    localparam int OFS_W = $clog2(BUS_W / 8);

    logic              go;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [31:0]       pattern;
    unit_e             unit;
    logic [ADDR_W-1:0] cur;
    logic [1:0]        phase;
    logic              busy;
    logic              finished;

    fill_regs #(
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we),
        .waddr_i   (cfg_addr),
        .wdata_i   (cfg_wdata),
        .raddr_i   (cfg_raddr),
        .rdata_o   (cfg_rdata),
        .busy_i    (busy),
        .finished_i(finished),
        .go_o      (go),
        .base_o    (base),
        .limit_o   (limit),
        .pattern_o (pattern),
        .unit_o    (unit)
    );

    fill_seq #(
        .ADDR_W(ADDR_W),
        .BUS_W (BUS_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .base_i    (base),
        .limit_i   (limit),
        .wr_ready_i(wr_ready),
        .wr_valid_o(wr_valid),
        .cur_o     (cur),
        .phase_o   (phase),
        .busy_o    (busy),
        .finished_o(finished),
        .done_o    (fill_done)
    );

    fill_packer #(
        .BUS_W(BUS_W)
    ) u_pack (
        .pattern_i(pattern),
        .unit_i   (unit),
        .phase_i  (phase),
        .word_o   (wr_data)
    );

    assign wr_addr = {cur, {OFS_W{1'b0}}};

    // R10: a stalled request holds still
    a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R2: an accepted word is followed by the next word address or no request
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == $past(wr_addr) + (1 << OFS_W))));

    // R3: requests stay inside the half-open range
    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_addr[ADDR_W+OFS_W-1:OFS_W] >= base) &&
                      (wr_addr[ADDR_W+OFS_W-1:OFS_W] < limit)));

    // R11: the completion pulse lasts one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !fill_done);

endmodule

// File: tb/tb_fill_engine.sv
module tb_fill_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cfg_raddr = '0;
    logic [31:0] cfg_rdata;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [34:0] wr_addr;
    logic [63:0] wr_data;
    logic        fill_done;

    fill_engine dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr),
        .cfg_rdata(cfg_rdata),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .fill_done(fill_done)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // expectation state for the monitor
    logic [31:0] e_base = '0;
    logic [31:0] e_value = '0;
    int          e_unit = 16;
    int          e_count = 0;
    int          widx = 0;
    int          done_cnt = 0;
    int          rdy_mode = 0;
    int          cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_word(input int unit, input logic [31:0] v, input int idx);
        logic [63:0] w;
        for (int j = 0; j < 8; j++) begin
            int o;
            int s;
            o = idx * 8 + j;
            if (unit == 32) s = o % 4;
            else if (unit == 24) s = o % 3;
            else s = o % 2;
            w[8*j +: 8] = v[8*s +: 8];
        end
        return w;
    endfunction

    // ready driven just after the rising edge
    always @(posedge clk) begin
        #1;
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: wr_ready = 1'b1;
            1: wr_ready = cyc[0];
            2: wr_ready = lfsr[0];
            default: wr_ready = 1'b0;
        endcase
    end

    // monitor at the falling edge
    logic        stall_q = 1'b0;
    logic [34:0] stall_addr = '0;
    logic [63:0] stall_data = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_q) begin
                chk(wr_valid && wr_addr == stall_addr && wr_data == stall_data,
                    "R10 stalled request held", {29'b0, wr_addr}, {29'b0, stall_addr});
            end
            stall_q    = wr_valid && !wr_ready;
            stall_addr = wr_addr;
            stall_data = wr_data;
            if (wr_valid && wr_ready) begin
                logic [34:0] ea;
                logic [63:0] ed;
                ea = (35'(e_base) + 35'(widx)) << 3;
                ed = exp_word(e_unit, e_value, widx);
                chk(widx < e_count, "R3 no write beyond range", 64'(widx), 64'(e_count));
                chk(wr_addr == ea, "R2 word address", {29'b0, wr_addr}, {29'b0, ea});
                if (e_unit == 32) chk(wr_data == ed, "R8 32-bit pattern", wr_data, ed);
                else if (e_unit == 24) chk(wr_data == ed, "R7 24-bit pattern", wr_data, ed);
                else chk(wr_data == ed, "R6 16-bit pattern", wr_data, ed);
                widx++;
            end
            if (fill_done) done_cnt++;
        end
    end

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        cfg_raddr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_done(input int base_cnt);
        int t;
        t = 0;
        while (done_cnt == base_cnt && t < 2000) begin
            @(negedge clk);
            #1;
            t++;
        end
        chk(done_cnt != base_cnt, "R11 fill completed", 64'(done_cnt), 64'(base_cnt + 1));
        @(negedge clk);
        #1;
        chk(done_cnt == base_cnt + 1, "R11 exactly one done pulse", 64'(done_cnt), 64'(base_cnt + 1));
    endtask

    task automatic run_fill(input logic [31:0] b, input logic [31:0] l, input logic [31:0] v,
                            input logic [1:0] md, input int rm);
        int          base_cnt;
        logic [31:0] rd;
        logic [31:0] ectl;
        e_base   = b;
        e_value  = v;
        e_unit   = md[1] ? 32 : (md[0] ? 24 : 16);
        e_count  = (l > b) ? int'(l - b) : 0;
        widx     = 0;
        base_cnt = done_cnt;
        rdy_mode = rm;
        cfg_write(2'd0, b);
        cfg_write(2'd1, l);
        cfg_write(2'd2, v);
        cfg_write(2'd3, {22'b0, md, 8'h01});
        cfg_read(2'd3, rd);
        chk(rd[0] == 1'b1 && rd[1] == 1'b0, "R4 busy after go, R5 finished cleared",
            64'(rd[1:0]), 64'h1);
        wait_done(base_cnt);
        chk(widx == e_count, "R3 write count", 64'(widx), 64'(e_count));
        ectl = {22'b0, md, 8'h02};
        cfg_read(2'd3, rd);
        chk(rd == ectl, "R5 control after completion (R4 busy clear)", 64'(rd), 64'(ectl));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          iter;
        int          bc;
        logic [31:0] starts [3];
        starts[0] = 32'd0;
        starts[1] = 32'd3;
        starts[2] = 32'd17;
        iter = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            cfg_read(2'(a), rd);
            chk(rd == 32'h0, "R1 register reset value", 64'(rd), 64'h0);
        end
        chk(!wr_valid && !fill_done, "R1 outputs idle after reset",
            {62'b0, wr_valid, fill_done}, 64'h0);

        // R1 readback while idle
        cfg_write(2'd0, 32'h1234_5678);
        cfg_write(2'd1, 32'h0BAD_F00D);
        cfg_write(2'd2, 32'hCAFE_0001);
        cfg_read(2'd0, rd);
        chk(rd == 32'h1234_5678, "R1 base readback", 64'(rd), 64'h12345678);
        cfg_read(2'd1, rd);
        chk(rd == 32'h0BAD_F00D, "R1 limit readback", 64'(rd), 64'h0BADF00D);
        cfg_read(2'd2, rd);
        chk(rd == 32'hCAFE_0001, "R1 value readback", 64'(rd), 64'hCAFE0001);

        // sweep over unit selection, base, length and ready pattern
        for (int md = 0; md < 4; md++) begin
            for (int si = 0; si < 3; si++) begin
                for (int len = 0; len < 10; len++) begin
                    for (int rm = 0; rm < 3; rm++) begin
                        logic [31:0] v;
                        v = 32'h1F2E_3D4C + 32'(iter) * 32'h0103_0507;
                        run_fill(starts[si], starts[si] + 32'(len), v, 2'(md), rm);
                        iter++;
                    end
                end
            end
        end

        // R3 inverted range: nothing written
        run_fill(32'd20, 32'd5, 32'h5566_7788, 2'b01, 0);

        // R2 addresses at the top of the count space
        run_fill(32'hFFFF_FFFC, 32'hFFFF_FFFF, 32'h00A1_B2C3, 2'b01, 2);

        // R9 writes while busy are ignored
        e_base   = 32'd40;
        e_value  = 32'h0011_2233;
        e_unit   = 16;
        e_count  = 6;
        widx     = 0;
        bc       = done_cnt;
        rdy_mode = 3;
        cfg_write(2'd0, 32'd40);
        cfg_write(2'd1, 32'd46);
        cfg_write(2'd2, 32'h0011_2233);
        cfg_write(2'd3, 32'h0000_0001);
        cfg_write(2'd0, 32'd100);
        cfg_write(2'd1, 32'd200);
        cfg_write(2'd2, 32'hDEAD_BEEF);
        cfg_write(2'd3, 32'h0000_0301);
        cfg_read(2'd0, rd);
        chk(rd == 32'd40, "R9 base unchanged while busy", 64'(rd), 64'd40);
        cfg_read(2'd1, rd);
        chk(rd == 32'd46, "R9 limit unchanged while busy", 64'(rd), 64'd46);
        cfg_read(2'd2, rd);
        chk(rd == 32'h0011_2233, "R9 value unchanged while busy", 64'(rd), 64'h00112233);
        cfg_read(2'd3, rd);
        chk(rd == 32'h0000_0001, "R9 control unchanged while busy", 64'(rd), 64'h1);
        chk(widx == 0, "R10 nothing accepted while ready low", 64'(widx), 64'h0);
        rdy_mode = 1;
        wait_done(bc);
        chk(widx == 6, "R9 running fill kept its range", 64'(widx), 64'd6);
        cfg_read(2'd3, rd);
        chk(rd == 32'h0000_0002, "R9 R5 control after protected fill", 64'(rd), 64'h2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule